// File: doc/BRIEF.md
# Register-Mapped SPI Master Controller

This block is an SPI master peripheral that a processor controls through a small register file. Software sets a bit-rate divisor and a command word. The command word chooses the frame length, the bit order, the clock polarity, the clock phase, and whether slave select stays low between frames. Writing a word into the data register starts a frame. The shift engine drives the serial clock and the output data line, and it samples the input line on the edge that the selected phase calls for.

The block runs in one of two modes. In full-duplex mode, each completed frame stores the received word and raises a receive-full flag. A second frame that ends before software has read that word raises an overrun flag instead. In transmit-only mode, received data is discarded. A transmit-empty flag rises as soon as a word moves into the shifter, so software can queue the next word while the current frame is still on the wire. One interrupt line combines the receive-full and transmit-empty flags, each gated by its own enable.

Top module: `spim_top`

## Requirements
- R1: After reset, the control register (address 0) reads 0, the status register (address 1) reads 0x2 (only transmit-empty set), slave select is high, the serial clock is low and the interrupt is low.
- R2: The data register (address 4) responds only to wide accesses (`bus_wide`=1). A narrow write to it is ignored, and transmit-empty stays set. A narrow read of it returns 0 and leaves receive-full unchanged.
- R3: During a frame, every half period of the serial clock lasts RATE+1 clock cycles. RATE is the 8-bit value at address 2, so the serial clock runs at the input clock divided by 2*(RATE+1).
- R4: The frame length comes from command bits [3:0] (address 3). Codes 7 to 15 give code+1 bits, 0 gives 20 bits, 1 gives 24 bits and 2 gives 32 bits. The unused codes 3 to 6 give 8 bits.
- R5: Command bit 4 selects LSB-first order when set and MSB-first order when clear. Bit 6 sets the idle clock level. With bit 7 clear, data is sampled on the leading edge of each bit. With bit 7 set, data is sampled on the trailing edge.
- R6: A wide write to the data register clears transmit-empty (status bit 1). The flag is set again when the word moves into the shifter. A word written during a frame is sent as the next frame.
- R7: In full-duplex mode (control bit 1 = 0), the end of a frame stores the received word and sets receive-full (status bit 0). A wide read of the data register returns that word and clears receive-full.
- R8: If a frame ends while receive-full is already set, the stored word is kept and overrun (status bit 2) is set. Writing status with bit 2 = 0 clears overrun. Writing bit 2 = 1 leaves it unchanged.
- R9: In transmit-only mode (control bit 1 = 1), a completed frame leaves receive-full and the stored word unchanged.
- R10: The interrupt output equals (receive-full AND control bit 3) OR (transmit-empty AND control bit 2).
- R11: Slave select (active low) is low for the whole of every frame. While enable (control bit 0) is 1 and command bit 5 is 1, it also stays low between frames. Otherwise it is high when no frame is running.
- R12: A write to the rate or command register during a frame changes nothing in that frame. The new value applies from the next frame.
- R13: Clearing enable stops a frame in progress and returns the clock to idle and slave select to high. No frame starts while enable is 0, and a written word waits with transmit-empty clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects only; read data is combinational) |
| bus_wide | input | 1 | 1 = access of 16 bits or more, 0 = byte access |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data for `bus_addr` |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_ss_n | output | 1 | Slave select, active low |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest state to reach is a configuration change or a second data write that lands while a frame is shifting. Both the latching of the rate and command at frame start and the back-to-back hand-over depend on it. The bench issues these writes a fixed number of cycles after the frame starts, when the shifter is known to be mid-frame. A monitor records every serial-clock toggle, measures the spacing between toggles, and rebuilds the transmitted word from the sampling edges. Each result is compared with the scoreboard entry queued for that frame. The serial input is fed from the output, optionally inverted, so the received word is known in advance for every length and order.

// File: rtl/spim_pkg.sv
package spim_pkg;
   localparam int unsigned FRAME_MAX = 32;

   localparam logic [2:0] AD_CTRL = 3'd0;
   localparam logic [2:0] AD_STAT = 3'd1;
   localparam logic [2:0] AD_RATE = 3'd2;
   localparam logic [2:0] AD_CMD  = 3'd3;
   localparam logic [2:0] AD_DATA = 3'd4;

   typedef struct packed {
      logic       cpha;
      logic       cpol;
      logic       hold;
      logic       lsb;
      logic [3:0] len_code;
   } cmd_t;

   // Mixed frame-length encoding: long frames use the low codes.
   function automatic logic [5:0] frame_bits(input logic [3:0] code);
      logic [5:0] n;
      case (code)
         4'h0:                   n = 6'd20;
         4'h1:                   n = 6'd24;
         4'h2:                   n = 6'd32;
         4'h3, 4'h4, 4'h5, 4'h6: n = 6'd8;
         default:                n = {2'b00, code} + 6'd1;
      endcase
      return n;
   endfunction
endpackage

// File: rtl/spim_baud.sv
module spim_baud #(
   parameter int RATE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [RATE_W-1:0] rate,
   output logic              tick
);
   logic [RATE_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= '0;
      else if (!run || cnt == rate) cnt <= '0;
      else                         cnt <= cnt + 1'b1;
   end

   assign tick = run && (cnt == rate);
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
   parameter int FRAME_W = 32,
   parameter int RATE_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               start,
   input  logic [FRAME_W-1:0] tx_word,
   input  logic [3:0]         len_code,
   input  logic               lsb_in,
   input  logic               cpol_in,
   input  logic               cpha_in,
   input  logic [RATE_W-1:0]  rate_in,
   input  logic               miso,
   output logic               busy,
   output logic               sclk,
   output logic               mosi,
   output logic               done,
   output logic [FRAME_W-1:0] rx_word
);
   localparam int IDX_W = $clog2(FRAME_W);
   localparam int CW    = IDX_W + 1;
   localparam int HW    = CW + 1;

   logic               lsb_f, cpol_f, cpha_f, tog, tick;
   logic [RATE_W-1:0]  rate_f;
   logic [FRAME_W-1:0] txw, rxw, rx_nxt;
   logic [CW-1:0]      nbits, ocnt, sidx;
   logic [HW-1:0]      hc, last;
   logic [IDX_W-1:0]   s_pos, o_pos;
   logic               sample_now, adv;

   spim_baud #(.RATE_W(RATE_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .run(busy), .rate(rate_f), .tick(tick)
   );

   assign sidx       = hc[HW-1:1];
   assign last       = {nbits, 1'b0} - 1'b1;
   assign s_pos      = IDX_W'(lsb_f ? sidx : nbits - 1'b1 - sidx);
   assign o_pos      = IDX_W'(lsb_f ? ocnt : nbits - 1'b1 - ocnt);
   assign sample_now = tick && (hc[0] == cpha_f);
   // Output advances on trailing edges (phase 0) or later leading edges (phase 1).
   assign adv        = cpha_f ? (!hc[0] && hc != '0) : (hc[0] && hc != last);

   always_comb begin
      rx_nxt = rxw;
      if (sample_now) rx_nxt[s_pos] = miso;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0; done <= 1'b0; tog <= 1'b0;
         lsb_f <= 1'b0; cpol_f <= 1'b0; cpha_f <= 1'b0;
         rate_f <= '0; txw <= '0; rxw <= '0; rx_word <= '0;
         nbits <= CW'(8); hc <= '0; ocnt <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start && en) begin
               busy   <= 1'b1;
               lsb_f  <= lsb_in;
               cpol_f <= cpol_in;
               cpha_f <= cpha_in;
               rate_f <= rate_in;
               txw    <= tx_word;
               nbits  <= CW'(spim_pkg::frame_bits(len_code));
               hc     <= '0;
               ocnt   <= '0;
               rxw    <= '0;
               tog    <= 1'b0;
            end
         end else if (!en) begin
            busy <= 1'b0;
            tog  <= 1'b0;
         end else if (tick) begin
            tog <= ~tog;
            hc  <= hc + 1'b1;
            rxw <= rx_nxt;
            if (adv) ocnt <= ocnt + 1'b1;
            if (hc == last) begin
               busy    <= 1'b0;
               done    <= 1'b1;
               rx_word <= rx_nxt;
            end
         end
      end
   end

   assign sclk = busy ? (cpol_f ^ tog) : cpol_in;
   assign mosi = txw[o_pos];
endmodule

// File: rtl/spim_regs.sv
module spim_regs
   import spim_pkg::*;
#(
   parameter int BUS_W   = 32,
   parameter int FRAME_W = 32,
   parameter int RATE_W  = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2:0]         addr,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic               wide,
   input  logic [BUS_W-1:0]   wdata,
   output logic [BUS_W-1:0]   rdata,
   input  logic               busy,
   input  logic               done,
   input  logic [FRAME_W-1:0] rx_word,
   output logic               start,
   output logic [FRAME_W-1:0] tx_word,
   output cmd_t               cmd,
   output logic [RATE_W-1:0]  rate,
   output logic               en,
   output logic               txonly,
   output logic               rxfull,
   output logic               ovr,
   output logic               rd_data,
   output logic               irq
);
   logic [3:0]         ctrl;
   logic               txempty, wr_data, irq_raw;
   logic [FRAME_W-1:0] rxbuf;

   assign en      = ctrl[0];
   assign txonly  = ctrl[1];
   assign wr_data = wr_en && wide && (addr == AD_DATA);
   assign rd_data = rd_en && wide && (addr == AD_DATA);
   assign start   = en && !txempty && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0; rate <= '0; cmd <= '0; tx_word <= '0;
         txempty <= 1'b1; rxbuf <= '0; rxfull <= 1'b0; ovr <= 1'b0;
      end else begin
         if (wr_en && addr == AD_CTRL) ctrl <= wdata[3:0];
         if (wr_en && addr == AD_RATE) rate <= wdata[RATE_W-1:0];
         if (wr_en && addr == AD_CMD)  cmd  <= cmd_t'(wdata[7:0]);
         if (wr_data) begin
            tx_word <= wdata[FRAME_W-1:0];
            txempty <= 1'b0;
         end else if (start) begin
            txempty <= 1'b1;
         end
         if (wr_en && addr == AD_STAT && !wdata[2]) ovr <= 1'b0;
         if (done && !txonly) begin
            if (rxfull && !rd_data) begin
               ovr <= 1'b1;
            end else begin
               rxbuf  <= rx_word;
               rxfull <= 1'b1;
            end
         end else if (rd_data) begin
            rxfull <= 1'b0;
         end
      end
   end

   always_comb begin
      case (addr)
         AD_CTRL: rdata = BUS_W'(ctrl);
         AD_STAT: rdata = BUS_W'({ovr, txempty, rxfull});
         AD_RATE: rdata = BUS_W'(rate);
         AD_CMD:  rdata = BUS_W'(cmd);
         AD_DATA: rdata = wide ? BUS_W'(rxbuf) : '0;
         default: rdata = '0;
      endcase
   end

   assign irq_raw = (rxfull && ctrl[3]) || (txempty && ctrl[2]);

   generate
      if (IRQ_REG) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= irq_raw;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = irq_raw;
      end
   endgenerate
endmodule

// File: rtl/spim_top.sv
module spim_top
   import spim_pkg::*;
#(
   parameter int BUS_W   = 32,
   parameter int FRAME_W = 32,
   parameter int RATE_W  = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       bus_addr,
   input  logic             bus_wr,
   input  logic             bus_rd,
   input  logic             bus_wide,
   input  logic [BUS_W-1:0] bus_wdata,
   output logic [BUS_W-1:0] bus_rdata,
   output logic             spi_sclk,
   output logic             spi_mosi,
   input  logic             spi_miso,
   output logic             spi_ss_n,
   output logic             irq
);
   generate
      if (FRAME_W != FRAME_MAX) begin : g_bad_frame
         $error("FRAME_W must match the longest encoded frame");
      end
      if (BUS_W < FRAME_W) begin : g_bad_bus
         $error("BUS_W must hold a whole frame");
      end
      if (RATE_W < 1) begin : g_bad_rate
         $error("RATE_W must be at least 1");
      end
   endgenerate

   logic               busy, done, start, en, txonly, rxfull, ovr, rd_data;
   logic [FRAME_W-1:0] rx_word, tx_word;
   logic [RATE_W-1:0]  rate;
   cmd_t               cmd;

   spim_regs #(
      .BUS_W(BUS_W), .FRAME_W(FRAME_W), .RATE_W(RATE_W), .IRQ_REG(IRQ_REG)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr_en(bus_wr),
      .rd_en(bus_rd), .wide(bus_wide), .wdata(bus_wdata), .rdata(bus_rdata),
      .busy(busy), .done(done), .rx_word(rx_word), .start(start),
      .tx_word(tx_word), .cmd(cmd), .rate(rate), .en(en), .txonly(txonly),
      .rxfull(rxfull), .ovr(ovr), .rd_data(rd_data), .irq(irq)
   );

   spim_shift #(.FRAME_W(FRAME_W), .RATE_W(RATE_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .en(en), .start(start), .tx_word(tx_word),
      .len_code(cmd.len_code), .lsb_in(cmd.lsb), .cpol_in(cmd.cpol),
      .cpha_in(cmd.cpha), .rate_in(rate), .miso(spi_miso), .busy(busy),
      .sclk(spi_sclk), .mosi(spi_mosi), .done(done), .rx_word(rx_word)
   );

   assign spi_ss_n = !(busy || (en && cmd.hold));
endmodule

// File: rtl/spim_chk.sv
module spim_chk (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic en,
   input logic txonly,
   input logic rxfull,
   input logic ovr,
   input logic rd_data,
   input logic ss_n
);
   assert_ss_low_in_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !ss_n) else $error("select high during a frame");

   assert_stop_on_disable_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !busy) else $error("engine ran while disabled");

   assert_overrun_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rxfull && !rd_data && !txonly) |=> ovr) else $error("overrun missed");

   assert_overrun_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> $past(done)) else $error("overrun without frame end");

   assert_rx_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !txonly && !rxfull) |=> rxfull) else $error("receive-full not set");

   assert_txonly_no_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && txonly && !rxfull) |=> !rxfull) else $error("capture in transmit-only");
endmodule

bind spim_top spim_chk u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .en(en),
   .txonly(txonly), .rxfull(rxfull), .ovr(ovr), .rd_data(rd_data),
   .ss_n(spi_ss_n)
);

// File: tb/tb_spim_top.sv
module tb_spim_top;
   localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_RATE = 3'd2,
                          A_CMD = 3'd3, A_DATA = 3'd4;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_wide = 1'b0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        spi_sclk, spi_mosi, spi_ss_n, irq;
   logic        miso_inv = 1'b0;
   wire         spi_miso = spi_mosi ^ miso_inv;

   always #10 clk = ~clk;

   spim_top dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wide(bus_wide), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso), .spi_ss_n(spi_ss_n), .irq(irq)
   );

   int n_chk = 0, n_fail = 0, sent = 0, mon_done = 0;
   bit finished = 1'b0, mon_off = 1'b1;

   typedef struct {
      logic [31:0] data;
      int          n;
      bit          lsb, cpha;
      int          half;
      string       tag;
   } exp_t;
   exp_t q[$];

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mask(input int n);
      return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
   endfunction

   function automatic logic [31:0] mk_cmd(input logic [3:0] code, input bit lsb,
                                          input bit hold, input bit cpol, input bit cpha);
      return {24'd0, cpha, cpol, hold, lsb, code};
   endfunction

   task automatic wr(input logic [2:0] a, input logic [31:0] d, input bit w);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wide = w; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_wide = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input bit w, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wide = w; bus_rd = 1'b1;
      #2 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0; bus_wide = 1'b0;
   endtask

   task automatic cfg(input logic [7:0] rate, input logic [31:0] cmd);
      mon_off = 1'b1;
      wr(A_RATE, {24'd0, rate}, 1'b1);
      wr(A_CMD, cmd, 1'b1);
      @(negedge clk);
      mon_off = 1'b0;
   endtask

   task automatic send(input logic [31:0] d, input int n, input bit lsb,
                       input bit cpha, input int half, input string tag);
      exp_t e;
      e.data = d; e.n = n; e.lsb = lsb; e.cpha = cpha; e.half = half; e.tag = tag;
      q.push_back(e);
      sent++;
      wr(A_DATA, d, 1'b1);
   endtask

   task automatic wait_frames();
      while (mon_done != sent) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   // Monitor: rebuilds each frame from the serial pins and checks timing.
   bit          m_act = 1'b0, m_gap_bad = 1'b0;
   logic        m_prev = 1'b0;
   int          m_k = 0, m_gap = 0;
   logic [31:0] m_got = '0;
   exp_t        m_cur;
   always @(negedge clk) begin
      if (mon_off) begin
         m_act  = 1'b0;
         m_prev = spi_sclk;
         m_gap  = 0;
      end else begin
         m_gap++;
         if (spi_sclk !== m_prev) begin
            if (!m_act) begin
               if (q.size() == 0) begin
                  chk(1'b0, "R6 unexpected clock edge", 32'd1, 32'd0);
               end else begin
                  m_cur = q.pop_front();
                  m_act = 1'b1; m_k = 0; m_got = '0; m_gap_bad = 1'b0;
               end
            end else if (m_gap != m_cur.half) begin
               m_gap_bad = 1'b1;
            end
            m_gap = 0;
            if (m_act) begin
               if ((m_k % 2) == int'(m_cur.cpha))
                  m_got[m_cur.lsb ? (m_k / 2) : (m_cur.n - 1 - m_k / 2)] = spi_mosi;
               m_k++;
               if (m_k == 2 * m_cur.n) begin
                  chk(m_got == (m_cur.data & mask(m_cur.n)),
                      {m_cur.tag, " R5 serial bits"}, m_got, m_cur.data & mask(m_cur.n));
                  chk(!m_gap_bad, {m_cur.tag, " R3 half period"}, 32'(m_gap_bad), 32'd0);
                  m_act = 1'b0;
                  mon_done++;
               end
            end
         end
         m_prev = spi_sclk;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", mon_done, sent);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [31:0] pat;
      int          lens [4];
      logic [3:0]  codes [4];
      codes = '{4'h0, 4'h1, 4'h2, 4'h4};
      lens  = '{20, 24, 32, 8};
      pat   = 32'hDEAD_BEEF;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(A_CTRL, 1'b1, v); chk(v == 0, "R1 control after reset", v, 0);
      rd(A_STAT, 1'b1, v); chk(v == 32'h2, "R1 status after reset", v, 32'h2);
      chk(spi_ss_n && !spi_sclk && !irq, "R1 pins after reset",
          {29'd0, spi_ss_n, spi_sclk, irq}, 32'h4);

      // R7 basic full-duplex frame, 8 bits, MSB first, mode 0
      cfg(8'd1, mk_cmd(4'h7, 0, 0, 0, 0));
      wr(A_CTRL, 32'h1, 1'b1);
      send(32'hA5, 8, 0, 0, 2, "R7 mode0");
      wait_frames();
      rd(A_STAT, 1'b1, v); chk(v == 32'h3, "R7 status after frame", v, 32'h3);
      chk(spi_ss_n, "R11 select high after frame without hold", 32'(spi_ss_n), 1);
      rd(A_DATA, 1'b1, v); chk(v == 32'hA5, "R7 received word", v, 32'hA5);
      rd(A_STAT, 1'b1, v); chk(v == 32'h2, "R7 read clears receive-full", v, 32'h2);

      // R2 narrow write to data ignored
      wr(A_DATA, 32'h55, 1'b0);
      repeat (20) @(negedge clk);
      rd(A_STAT, 1'b1, v); chk(v == 32'h2, "R2 narrow write ignored", v, 32'h2);

      // R5 LSB first, 16 bits, mode 3, inverted loopback
      cfg(8'd0, mk_cmd(4'hF, 1, 0, 1, 1));
      miso_inv = 1'b1;
      send(32'h1234, 16, 1, 1, 1, "R5 lsb mode3");
      wait_frames();
      miso_inv = 1'b0;
      rd(A_DATA, 1'b0, v); chk(v == 0, "R2 narrow read returns zero", v, 0);
      rd(A_STAT, 1'b1, v); chk(v[0] == 1'b1, "R2 narrow read keeps receive-full", v, 32'h3);
      rd(A_DATA, 1'b1, v); chk(v == 32'hEDCB, "R5 inverted received word", v, 32'hEDCB);

      // R4 long and reserved length codes
      for (int i = 0; i < 4; i++) begin
         cfg(8'd0, mk_cmd(codes[i], 0, 0, 0, 1));
         send(pat, lens[i], 0, 1, 1, "R4 length code");
         wait_frames();
         rd(A_DATA, 1'b1, v);
         chk(v == (pat & mask(lens[i])), "R4 frame length", v, pat & mask(lens[i]));
      end

      // R8 overrun
      cfg(8'd1, mk_cmd(4'h7, 0, 0, 0, 0));
      send(32'h11, 8, 0, 0, 2, "R8 first");
      wait_frames();
      send(32'h22, 8, 0, 0, 2, "R8 second");
      wait_frames();
      rd(A_STAT, 1'b1, v); chk(v == 32'h7, "R8 overrun set", v, 32'h7);
      rd(A_DATA, 1'b1, v); chk(v == 32'h11, "R8 old word kept", v, 32'h11);
      wr(A_STAT, 32'h4, 1'b0);
      rd(A_STAT, 1'b1, v); chk(v == 32'h6, "R8 write of one keeps overrun", v, 32'h6);
      wr(A_STAT, 32'h0, 1'b0);
      rd(A_STAT, 1'b1, v); chk(v == 32'h2, "R8 write of zero clears overrun", v, 32'h2);

      // R9 transmit-only
      wr(A_CTRL, 32'h3, 1'b1);
      send(32'h5A, 8, 0, 0, 2, "R9 tx-only");
      wait_frames();
      rd(A_STAT, 1'b1, v); chk(v == 32'h2, "R9 no capture", v, 32'h2);

      // R10 interrupt gating
      wr(A_CTRL, 32'h5, 1'b1);
      @(negedge clk); chk(irq, "R10 transmit-empty interrupt", 32'(irq), 1);
      wr(A_CTRL, 32'h9, 1'b1);
      @(negedge clk); chk(!irq, "R10 receive interrupt idle", 32'(irq), 0);
      send(32'h3C, 8, 0, 0, 2, "R10 rx irq");
      wait_frames();
      chk(irq, "R10 receive interrupt", 32'(irq), 1);
      rd(A_DATA, 1'b1, v);
      @(negedge clk); chk(!irq, "R10 interrupt cleared by read", 32'(irq), 0);
      wr(A_CTRL, 32'h1, 1'b1);

      // R11 hold select
      cfg(8'd0, mk_cmd(4'h7, 0, 1, 0, 0));
      chk(!spi_ss_n, "R11 hold asserts select", 32'(spi_ss_n), 0);
      send(32'h81, 8, 0, 0, 1, "R11 hold frame");
      wait_frames();
      chk(!spi_ss_n, "R11 select kept after frame", 32'(spi_ss_n), 0);
      rd(A_DATA, 1'b1, v);
      wr(A_CTRL, 32'h0, 1'b1);
      @(negedge clk); chk(spi_ss_n, "R11 disable releases select", 32'(spi_ss_n), 1);

      // R6 back-to-back frames
      wr(A_CTRL, 32'h3, 1'b1);
      cfg(8'd2, mk_cmd(4'h7, 0, 0, 0, 0));
      send(32'hC3, 8, 0, 0, 3, "R6 first");
      rd(A_STAT, 1'b1, v); chk(v[1] == 1'b1, "R6 empty while shifting", v, 32'h2);
      send(32'h69, 8, 0, 0, 3, "R6 second");
      wait_frames();
      chk(mon_done == sent, "R6 both frames sent", 32'(mon_done), 32'(sent));

      // R12 rate and command change mid-frame
      cfg(8'd3, mk_cmd(4'h7, 0, 0, 0, 0));
      send(32'h96, 8, 0, 0, 4, "R12 old config");
      repeat (10) @(negedge clk);
      wr(A_RATE, 32'h0, 1'b1);
      wr(A_CMD, mk_cmd(4'h7, 1, 0, 0, 0), 1'b1);
      send(32'h96, 8, 1, 0, 1, "R12 new config");
      wait_frames();

      // R13 disable mid-frame
      mon_off = 1'b1;
      cfg(8'd3, mk_cmd(4'hF, 0, 0, 0, 0));
      mon_off = 1'b1;
      wr(A_DATA, 32'hFFFF, 1'b1);
      repeat (20) @(negedge clk);
      wr(A_CTRL, 32'h2, 1'b1);
      repeat (2) @(negedge clk);
      chk(spi_ss_n && !spi_sclk, "R13 abort returns pins idle",
          {30'd0, spi_ss_n, spi_sclk}, 32'h2);
      wr(A_DATA, 32'h1234, 1'b1);
      repeat (20) @(negedge clk);
      chk(spi_ss_n, "R13 no frame while disabled", 32'(spi_ss_n), 1);
      rd(A_STAT, 1'b1, v); chk(v[1] == 1'b0, "R13 word waits", v, 32'h0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule